// File: doc/BRIEF.md
# E3 Far-End Alarm Persistence Detector

This block sits behind an E3 receive framer. Once per received frame the framer hands it the maintenance and adaptation byte, together with a flag saying whether frame alignment is currently held. The block watches the far-end receive failure bit in that byte and filters it through a persistence check. The alarm is declared only after the bit has read 1 in a run of consecutive frames. It is withdrawn only after the bit has read 0 in a run of the same length. The run length is 3 or 5 frames, chosen by a configuration bit.

Every change of the filtered alarm sets a sticky interrupt flag. A read of the interrupt register clears that flag. The flag, gated by an enable bit, drives an interrupt request line. A small register port gives a microprocessor access to the configuration, the live alarm state and the interrupt flag. While the framer reports loss of alignment, the incoming bytes are not trusted: the run counter is held at zero and the alarm state is frozen.

Top module: `e3_ferf_persist`

## Requirements
- R1: After reset the live alarm, the interrupt flag, the interrupt enable, the run-length select and the interrupt request are all 0.
- R2: Only bit 7 of the received byte is the alarm bit. The other seven bits have no effect on any output.
- R3: With the run-length select (register 0, bit 0) at 0, the live alarm (register 1, bit 0) rises on the clock edge that takes in the 3rd consecutive in-sync frame with bit 7 = 1.
- R4: With the run-length select at 1, the live alarm rises on the edge that takes in the 5th such frame, and not earlier.
- R5: While the alarm is 0, a frame with bit 7 = 0 restarts the run, so the count toward declaration begins again from zero.
- R6: While the alarm is 1, it falls after the same number of consecutive frames with bit 7 = 0. A frame with bit 7 = 1 restarts that clearing run.
- R7: While the in-sync input is 0, frames are ignored and the run count is held at zero. The alarm does not change, and counting after re-sync starts over.
- R8: Every rise and every fall of the live alarm sets the interrupt flag (register 2, bit 0) on the same edge.
- R9: Reading register 2 returns the flag, and the flag reads 0 from the next cycle on. If an alarm change falls in the same cycle as that read, the flag stays 1.
- R10: The interrupt request output is 1 exactly when the interrupt flag and the interrupt enable (register 0, bit 1) are both 1.
- R11: Register 0 bits 1:0 are read/write and read back as written, with all other read bits 0. Register 1 and register 2 ignore writes. Register 3 reads 0. Read data is combinational from the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ma_valid | input | 1 | One-cycle strobe: a new frame's byte is present |
| ma_byte | input | 8 | Maintenance and adaptation byte of the frame |
| in_sync | input | 1 | Framer holds frame alignment |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears the interrupt flag on register 2) |
| reg_addr | input | ADDR_W | Register index |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| ferf_status | output | 1 | Live filtered far-end failure state |
| ferf_int_flag | output | 1 | Sticky change-of-alarm interrupt flag |
| ferf_int_en | output | 1 | Interrupt enable bit |
| irq | output | 1 | Interrupt request |

## Verification
The bound checker verifies several rules on every cycle. A frame that agrees with the current alarm state never flips it. Nothing flips the alarm while alignment is lost or when no frame arrives. Each flip leaves the flag set. The flag holds until a read and drops after a read unless a flip coincided. The request line stays low while disabled. The exact run lengths of 3 and 5 frames, the restart of a run after a disagreeing frame or a re-sync, and the register read-back values can only be shown by the bench. There, a behavioural model is compared against the design on every clock while the scenarios drive these sequences.

// File: rtl/e3_ferf_pkg.sv
package e3_ferf_pkg;
   localparam int REG_W = 8;

   // register indices
   localparam int IDX_CTRL = 0;   // bit0 run-length select, bit1 interrupt enable
   localparam int IDX_STAT = 1;   // bit0 live alarm
   localparam int IDX_INT  = 2;   // bit0 change flag, read-to-clear

   localparam int CTRL_LONG_BIT = 0;
   localparam int CTRL_IEN_BIT  = 1;

   typedef struct packed {
      logic long_sel;
      logic int_en;
   } ctrl_t;
endpackage

// File: rtl/e3_ferf_runcount.sv
module e3_ferf_runcount #(
   parameter int SHORT_RUN = 3,
   parameter int LONG_RUN  = 5,
   localparam int CNT_W    = $clog2(LONG_RUN + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic frame_stb,
   input  logic alarm_bit,
   input  logic in_sync,
   input  logic long_sel,
   output logic alarm_state,
   output logic change
);
   localparam logic [CNT_W-1:0] SHORT_C = CNT_W'(SHORT_RUN);
   localparam logic [CNT_W-1:0] LONG_C  = CNT_W'(LONG_RUN);

   logic [CNT_W-1:0] run_cnt;
   logic [CNT_W-1:0] run_nxt;
   logic [CNT_W-1:0] limit;
   logic             disagree;

   generate
      if (SHORT_RUN == LONG_RUN) begin : g_fixed_limit
         logic unused_sel;
         assign unused_sel = long_sel;
         assign limit      = SHORT_C;
      end else begin : g_select_limit
         assign limit = long_sel ? LONG_C : SHORT_C;
      end
   endgenerate

   always_comb begin
      disagree = in_sync && frame_stb && (alarm_bit != alarm_state);
      run_nxt  = run_cnt + CNT_W'(1);
      change   = disagree && (run_nxt >= limit);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_cnt     <= '0;
         alarm_state <= 1'b0;
      end else if (!in_sync) begin
         run_cnt <= '0;
      end else if (frame_stb) begin
         if (!disagree) begin
            run_cnt <= '0;
         end else if (change) begin
            run_cnt     <= '0;
            alarm_state <= ~alarm_state;
         end else begin
            run_cnt <= run_nxt;
         end
      end
   end
endmodule

// File: rtl/e3_ferf_regs.sv
module e3_ferf_regs
   import e3_ferf_pkg::*;
#(
   parameter int ADDR_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [REG_W-1:0]  reg_wdata,
   input  logic              alarm_state,
   input  logic              change,
   output ctrl_t             ctrl,
   output logic              int_flag,
   output logic [REG_W-1:0]  reg_rdata
);
   logic sel_ctrl, sel_stat, sel_int;
   logic unused_wbits;

   assign sel_ctrl     = (reg_addr == ADDR_W'(IDX_CTRL));
   assign sel_stat     = (reg_addr == ADDR_W'(IDX_STAT));
   assign sel_int      = (reg_addr == ADDR_W'(IDX_INT));
   assign unused_wbits = ^reg_wdata[REG_W-1:2];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl <= '0;
      end else if (reg_wr && sel_ctrl) begin
         ctrl.long_sel <= reg_wdata[CTRL_LONG_BIT];
         ctrl.int_en   <= reg_wdata[CTRL_IEN_BIT];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         int_flag <= 1'b0;
      end else if (change) begin
         int_flag <= 1'b1;
      end else if (reg_rd && sel_int) begin
         int_flag <= 1'b0;
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (sel_ctrl) begin
         reg_rdata[CTRL_LONG_BIT] = ctrl.long_sel;
         reg_rdata[CTRL_IEN_BIT]  = ctrl.int_en;
      end else if (sel_stat) begin
         reg_rdata[0] = alarm_state;
      end else if (sel_int) begin
         reg_rdata[0] = int_flag;
      end
   end
endmodule

// File: rtl/e3_ferf_persist.sv
module e3_ferf_persist
   import e3_ferf_pkg::*;
#(
   parameter int ALARM_BIT = 7,
   parameter int SHORT_RUN = 3,
   parameter int LONG_RUN  = 5,
   parameter int ADDR_W    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ma_valid,
   input  logic [7:0]        ma_byte,
   input  logic              in_sync,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   output logic              ferf_status,
   output logic              ferf_int_flag,
   output logic              ferf_int_en,
   output logic              irq
);
   generate
      if (ALARM_BIT < 0 || ALARM_BIT > 7) begin : g_bad_bit
         $error("ALARM_BIT must select a bit of the byte");
      end
      if (SHORT_RUN < 1 || LONG_RUN < SHORT_RUN) begin : g_bad_run
         $error("need 1 <= SHORT_RUN <= LONG_RUN");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("ADDR_W must cover three registers");
      end
   endgenerate

   ctrl_t ctrl;
   logic  change;
   logic  unused_ma;

   assign unused_ma = ^ma_byte;

   e3_ferf_runcount #(
      .SHORT_RUN (SHORT_RUN),
      .LONG_RUN  (LONG_RUN)
   ) u_run (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_stb   (ma_valid),
      .alarm_bit   (ma_byte[ALARM_BIT]),
      .in_sync     (in_sync),
      .long_sel    (ctrl.long_sel),
      .alarm_state (ferf_status),
      .change      (change)
   );

   e3_ferf_regs #(
      .ADDR_W (ADDR_W)
   ) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .reg_wr      (reg_wr),
      .reg_rd      (reg_rd),
      .reg_addr    (reg_addr),
      .reg_wdata   (reg_wdata),
      .alarm_state (ferf_status),
      .change      (change),
      .ctrl        (ctrl),
      .int_flag    (ferf_int_flag),
      .reg_rdata   (reg_rdata)
   );

   assign ferf_int_en = ctrl.int_en;
   assign irq         = ferf_int_flag & ctrl.int_en;
endmodule

// File: rtl/e3_ferf_persist_chk.sv
module e3_ferf_persist_chk #(
   parameter int ALARM_BIT = 7,
   parameter int ADDR_W    = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ma_valid,
   input logic [7:0]        ma_byte,
   input logic              in_sync,
   input logic              reg_rd,
   input logic [ADDR_W-1:0] reg_addr,
   input logic              ferf_status,
   input logic              ferf_int_flag,
   input logic              ferf_int_en,
   input logic              irq
);
   logic int_read;
   assign int_read = reg_rd && (reg_addr == ADDR_W'(e3_ferf_pkg::IDX_INT));

   // R5: an agreeing zero frame never declares
   a_r5_zero_keeps_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (ma_valid && in_sync && !ma_byte[ALARM_BIT] && !ferf_status) |=> !ferf_status);

   // R6: an agreeing one frame never clears
   a_r6_one_keeps_set: assert property (@(posedge clk) disable iff (!rst_n)
      (ma_valid && in_sync && ma_byte[ALARM_BIT] && ferf_status) |=> ferf_status);

   // R7: no alarm change without an in-sync frame
   a_r7_frozen_out_of_sync: assert property (@(posedge clk) disable iff (!rst_n)
      !(ma_valid && in_sync) |=> $stable(ferf_status));

   // R8: a flip of the alarm leaves the flag set
   a_r8_change_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (ferf_status != $past(ferf_status)) |-> ferf_int_flag);

   // R9: flag sticky without a read
   a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ferf_int_flag && !int_read) |=> ferf_int_flag);

   // R9: read clears unless a flip coincides
   a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      int_read |=> (!ferf_int_flag || (ferf_status != $past(ferf_status))));

   // R10: no request while disabled or flag low
   a_r10_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
      (!ferf_int_en || !ferf_int_flag) |-> !irq);
endmodule

bind e3_ferf_persist e3_ferf_persist_chk #(
   .ALARM_BIT (ALARM_BIT),
   .ADDR_W    (ADDR_W)
) u_chk (.*);

// File: tb/tb_e3_ferf_persist.sv
`timescale 1ns/1ps
module tb_e3_ferf_persist;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       ma_valid;
   logic [7:0] ma_byte;
   logic       in_sync;
   logic       reg_wr;
   logic       reg_rd;
   logic [1:0] reg_addr;
   logic [7:0] reg_wdata;
   logic [7:0] reg_rdata;
   logic       ferf_status, ferf_int_flag, ferf_int_en, irq;

   int    vectors = 0;
   int    miscompares = 0;
   string cur_req = "R1";

   // reference model state
   int m_cnt  = 0;
   bit m_stat = 0, m_flag = 0, m_long = 0, m_en = 0;

   always #10 clk = ~clk;

   e3_ferf_persist dut (
      .clk(clk), .rst_n(rst_n), .ma_valid(ma_valid), .ma_byte(ma_byte),
      .in_sync(in_sync), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ferf_status(ferf_status),
      .ferf_int_flag(ferf_int_flag), .ferf_int_en(ferf_int_en), .irq(irq)
   );

   task automatic model_step();
      bit ev = 0;
      int lim;
      if (!rst_n) begin
         m_cnt = 0; m_stat = 0; m_flag = 0; m_long = 0; m_en = 0;
         return;
      end
      lim = m_long ? 5 : 3;
      if (!in_sync) m_cnt = 0;
      else if (ma_valid) begin
         if (ma_byte[7] == m_stat) m_cnt = 0;
         else begin
            m_cnt++;
            if (m_cnt >= lim) begin m_stat = !m_stat; m_cnt = 0; ev = 1; end
         end
      end
      if (reg_rd && reg_addr == 2) m_flag = 0;
      if (ev) m_flag = 1;
      if (reg_wr && reg_addr == 0) begin m_long = reg_wdata[0]; m_en = reg_wdata[1]; end
   endtask

   task automatic chk(string what, int act, int exp);
      vectors++;
      if (act != exp) begin
         miscompares++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", cur_req, what, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      int exp_rd;
      case (reg_addr)
         2'd0: exp_rd = {m_en, m_long};
         2'd1: exp_rd = m_stat;
         2'd2: exp_rd = m_flag;
         default: exp_rd = 0;
      endcase
      chk("ferf_status", ferf_status, m_stat);
      chk("ferf_int_flag", ferf_int_flag, m_flag);
      chk("ferf_int_en", ferf_int_en, m_en);
      chk("irq", irq, m_flag & m_en);
      chk("reg_rdata", reg_rdata, exp_rd);
   endtask

   // one clock: inputs already applied; model updates at the edge, compare 5 ns later
   task automatic cyc();
      @(posedge clk);
      model_step();
      #5;
      compare_all();
      ma_valid = 0; reg_wr = 0; reg_rd = 0;
   endtask

   task automatic frame(input logic [7:0] b, input int gap = 2);
      ma_valid = 1; ma_byte = b;
      cyc();
      for (int i = 0; i < gap; i++) cyc();
   endtask

   task automatic wr(input int a, input int d);
      reg_wr = 1; reg_addr = 2'(a); reg_wdata = 8'(d);
      cyc();
   endtask

   task automatic rd(input int a);
      reg_rd = 1; reg_addr = 2'(a);
      cyc();
   endtask

   initial begin
      #4_000_000;
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      rst_n = 0; ma_valid = 0; ma_byte = 0; in_sync = 1;
      reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
      #5;
      cur_req = "R1";
      repeat (3) cyc();
      rst_n = 1;
      cyc();

      cur_req = "R11"; // ctrl read-back, status/int registers ignore writes
      wr(0, 8'hFF); rd(0); wr(1, 8'hFF); wr(2, 8'hFF);
      reg_addr = 3; cyc();
      wr(0, 0);

      cur_req = "R2"; // other bits never count
      repeat (6) frame(8'h7F);

      cur_req = "R3"; // 3-frame declaration, R8 flag on rise
      frame(8'h80); frame(8'h80);
      reg_addr = 1; cyc();
      frame(8'h80);
      reg_addr = 2; cyc();

      cur_req = "R10";
      wr(0, 8'h02); cyc();
      cur_req = "R9"; // read clears flag, irq drops
      rd(2); cyc();

      cur_req = "R6"; // clearing run restarted by a one frame
      frame(8'h00); frame(8'h00); frame(8'h80);
      frame(8'h00); frame(8'h00); frame(8'h00);
      cur_req = "R8";
      reg_addr = 2; cyc(); rd(2);

      cur_req = "R5"; // zero frame restarts declaration run
      frame(8'h80); frame(8'h80); frame(8'h00);
      frame(8'h80); frame(8'h80); frame(8'h80);
      rd(2);

      cur_req = "R7"; // loss of alignment freezes alarm and resets count
      frame(8'h00); frame(8'h00);
      in_sync = 0; frame(8'h00); frame(8'h00); frame(8'h00);
      in_sync = 1; frame(8'h00); frame(8'h00);
      reg_addr = 1; cyc();
      frame(8'h00);

      cur_req = "R4"; // 5-frame declaration
      wr(0, 8'h03);
      for (int k = 0; k < 5; k++) frame(8'h80);
      cur_req = "R9"; // read coinciding with a change keeps flag
      for (int k = 0; k < 4; k++) frame(8'h00);
      ma_valid = 1; ma_byte = 8'h00; reg_rd = 1; reg_addr = 2;
      cyc();
      reg_addr = 2; cyc(); cyc();
      rd(2); cyc();

      cur_req = "R1"; // reset mid-operation
      wr(0, 8'h03); frame(8'h80);
      rst_n = 0; cyc(); rst_n = 1; cyc();

      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule